// File: doc/BRIEF.md
# Zero-One Sweep Controller for a Sorting Pipeline

This block measures how many binary test vectors an external compare-exchange pipeline sorts correctly. The host writes a lane count `k` and pulses start. The block then drives every `k`-bit pattern, from 2^k − 2 down to zero, into the pipeline at one pattern per clock. It judges each word that comes back, counts the good ones, and, once the last real pattern has drained through, copies the tally into a report register and raises a done flag for the host to poll.

The all-ones pattern is never issued, because every network sorts it correctly. A word is judged correct when, reading upward from lane 1 (bit 0) to lane `k`, it has zero or more zeros followed only by ones, with at least one one. An all-zero word is therefore always judged incorrect. This means the zeros left in a freshly cleared pipeline can never be counted, so the block needs no per-vector valid tracking. After reaching zero, the pattern counter wraps and keeps running to flush the pipeline. A wrapped flag, together with a counter threshold equal to the total pipeline depth `D`, ends the sweep and freezes the tally.

Top module: `zo_sweep_ctrl`

## Requirements
- R1: A start pulse while idle loads the pattern counter with 2^k − 2, where `k` is taken as 1 when 0 is written and as 16 when more than 16 is written. The same pulse raises `pipe_flush_o` for that cycle and clears done, the tally and the wrapped flag. The loaded pattern appears on `test_vec_o` in the cycle after the start edge.
- R2: While sweeping, the pattern drops by one each clock. Lanes at bit positions ≥ k are driven to 0. While idle, `test_vec_o` is all zero.
- R3: A returned word is judged correct only when its bits 0..k−1 read as zeros followed only by ones and contain at least one one. Bits at positions ≥ k play no part in the verdict.
- R4: Judging takes three register stages. The word on `pipe_res_i` in a cycle adds at most one to the tally three clocks later, and only while a sweep runs.
- R5: After the counter passes zero it wraps to 2^16 − 1 and keeps counting down. The sweep stops in the cycle where the wrapped flag is set and the counter equals 2^16 − D. No pattern issued after the wrap is ever counted.
- R6: At the stop cycle the report register takes the tally, including any increment made in that same cycle. Done rises C + D + 1 clock edges after the start edge, where C = 2^k − 2.
- R7: Start pulses and changes on `k_i` during a sweep are ignored.
- R8: After reset, done, report, `test_vec_o` and `pipe_flush_o` are all 0.
- R9: Done stays at 1 until the next accepted start, and clears on the edge that accepts it. The report keeps its previous value until the new sweep ends.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Sweep start request |
| k_i | input | 5 | Number of lanes under test |
| test_vec_o | output | 16 | Pattern driven into the pipeline |
| pipe_flush_o | output | 1 | One-cycle clear for the external pipeline |
| pipe_res_i | input | 16 | Word returned by the pipeline |
| report_o | output | 16 | Count of correctly sorted patterns from the last sweep |
| done_o | output | 1 | Sweep finished |

## Verification
The final real pattern (zero) reaches the last judging stage in exactly the cycle where the wrapped counter hits its stop value, so the tally increment and the report latch fall on the same edge. A bench pipeline mode that inverts its input turns the zero pattern into all ones, a correct word. The report is then compared with a count that includes that last hit. An identity mode separately checks that wrapped patterns, which would look sorted, are never added.

// File: rtl/zo_pkg.sv
package zo_pkg;

    // Map a requested lane count onto the legal range 1..lanes.
    function automatic int unsigned clamp_lanes(int unsigned req, int unsigned lanes);
        if (req == 0) return 1;
        if (req > lanes) return lanes;
        return req;
    endfunction

    typedef enum logic {
        SWP_IDLE = 1'b0,
        SWP_RUN  = 1'b1
    } sweep_st_e;

endpackage

// File: rtl/zo_pattern_gen.sv
module zo_pattern_gen
    import zo_pkg::*;
#(
    parameter int LANES = 16,
    parameter int DEPTH = 87,
    localparam int KW = $clog2(LANES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [KW-1:0]    k_req,
    output logic             busy,
    output logic             launch,
    output logic             stop,
    output logic [LANES-1:0] lane_mask,
    output logic [LANES-1:0] pattern
);

    localparam logic [LANES-1:0] STOP_VAL = LANES'((33'd1 << LANES) - 33'(DEPTH));

    typedef struct packed {
        sweep_st_e        st;
        logic             wrapped;
        logic [LANES-1:0] cnt;
        logic [KW-1:0]    kq;
    } gen_t;

    gen_t gen_d, gen_q;
    logic [KW-1:0] k_sel;

    always_comb begin
        k_sel     = KW'(clamp_lanes(32'(k_req), LANES));
        launch    = start && (gen_q.st == SWP_IDLE);
        stop      = (gen_q.st == SWP_RUN) && gen_q.wrapped && (gen_q.cnt == STOP_VAL);
        lane_mask = LANES'((33'd1 << gen_q.kq) - 33'd1);
        busy      = (gen_q.st == SWP_RUN);
        pattern   = busy ? (gen_q.cnt & lane_mask) : '0;

        gen_d = gen_q;
        if (launch) begin
            gen_d.st      = SWP_RUN;
            gen_d.wrapped = 1'b0;
            gen_d.kq      = k_sel;
            gen_d.cnt     = LANES'((33'd1 << k_sel) - 33'd2);
        end else if (busy) begin
            gen_d.cnt = gen_q.cnt - 1'b1;
            if (gen_q.cnt == '0) gen_d.wrapped = 1'b1;
            if (stop) gen_d.st = SWP_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q <= '{st: SWP_IDLE, wrapped: 1'b0, cnt: '0, kq: KW'(1)};
        end else begin
            gen_q <= gen_d;
        end
    end

endmodule

// File: rtl/zo_order_judge.sv
module zo_order_judge #(
    parameter int LANES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [LANES-1:0] word,
    input  logic [LANES-1:0] lane_mask,
    output logic             good
);

    typedef struct packed {
        logic [LANES-1:0] zeros_s1;
        logic             any1_s1;
        logic             shape_s2;
        logic             any1_s2;
        logic             good_s3;
    } judge_t;

    judge_t jd_d, jd_q;
    logic [LANES-1:0] zinc;

    always_comb begin
        zinc = jd_q.zeros_s1 + 1'b1;
        jd_d = jd_q;
        if (clr) begin
            jd_d = '0;
        end else begin
            // Stage 1: mark zero lanes inside the window, note any one present.
            jd_d.zeros_s1 = ~word & lane_mask;
            jd_d.any1_s1  = |(word & lane_mask);
            // Stage 2: zero lanes must form one run starting at lane 1.
            jd_d.shape_s2 = ((jd_q.zeros_s1 & zinc) == '0);
            jd_d.any1_s2  = jd_q.any1_s1;
            // Stage 3: final verdict.
            jd_d.good_s3  = jd_q.shape_s2 && jd_q.any1_s2;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) jd_q <= '0;
        else        jd_q <= jd_d;
    end

    assign good = jd_q.good_s3;

endmodule

// File: rtl/zo_tally.sv
module zo_tally #(
    parameter int LANES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             busy,
    input  logic             hit,
    input  logic             stop,
    output logic [LANES-1:0] acc,
    output logic [LANES-1:0] report,
    output logic             done
);

    typedef struct packed {
        logic [LANES-1:0] acc;
        logic [LANES-1:0] report;
        logic             done;
    } tally_t;

    tally_t tl_d, tl_q;
    logic [LANES-1:0] acc_next;

    always_comb begin
        acc_next = tl_q.acc + LANES'(busy && hit);
        tl_d     = tl_q;
        if (clr) begin
            tl_d.acc  = '0;
            tl_d.done = 1'b0;
        end else begin
            tl_d.acc = acc_next;
            if (stop) begin
                tl_d.report = acc_next;
                tl_d.done   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tl_q <= '0;
        else        tl_q <= tl_d;
    end

    assign acc    = tl_q.acc;
    assign report = tl_q.report;
    assign done   = tl_q.done;

endmodule

// File: rtl/zo_sweep_ctrl.sv
module zo_sweep_ctrl #(
    parameter int LANES = 16,
    parameter int DEPTH = 87,
    localparam int KW = $clog2(LANES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [KW-1:0]    k_i,
    output logic [LANES-1:0] test_vec_o,
    output logic             pipe_flush_o,
    input  logic [LANES-1:0] pipe_res_i,
    output logic [LANES-1:0] report_o,
    output logic             done_o
);

    logic             busy;
    logic             launch;
    logic             stop;
    logic             hit;
    logic [LANES-1:0] lane_mask;
    logic [LANES-1:0] acc;

    zo_pattern_gen #(.LANES(LANES), .DEPTH(DEPTH)) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_i),
        .k_req     (k_i),
        .busy      (busy),
        .launch    (launch),
        .stop      (stop),
        .lane_mask (lane_mask),
        .pattern   (test_vec_o)
    );

    zo_order_judge #(.LANES(LANES)) u_judge (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (launch),
        .word      (pipe_res_i),
        .lane_mask (lane_mask),
        .good      (hit)
    );

    zo_tally #(.LANES(LANES)) u_tally (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (launch),
        .busy   (busy),
        .hit    (hit),
        .stop   (stop),
        .acc    (acc),
        .report (report_o),
        .done   (done_o)
    );

    assign pipe_flush_o = launch;

endmodule

// File: rtl/zo_sweep_ctrl_chk.sv
module zo_sweep_ctrl_chk #(
    parameter int LANES = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             done_o,
    input logic             pipe_flush_o,
    input logic [LANES-1:0] test_vec_o,
    input logic             busy,
    input logic [LANES-1:0] acc
);

    p_flush_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_flush_o |=> (!done_o && acc == '0 && busy));

    p_pattern_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && $past(test_vec_o) != '0 && !$past(pipe_flush_o))
        |-> test_vec_o == $past(test_vec_o) - 1'b1);

    p_tally_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && !$past(pipe_flush_o))
        |-> (acc == $past(acc) || acc == $past(acc) + 1'b1));

    p_done_after_sweep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(busy));

    p_done_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

endmodule

bind zo_sweep_ctrl zo_sweep_ctrl_chk #(.LANES(LANES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .done_o       (done_o),
    .pipe_flush_o (pipe_flush_o),
    .test_vec_o   (test_vec_o),
    .busy         (busy),
    .acc          (acc)
);

// File: tb/zo_sweep_ctrl_tb.sv
`timescale 1ns/1ps
module zo_sweep_ctrl_tb;

    localparam int D = 8;
    localparam int E = D - 3;

    typedef struct packed {
        logic [4:0] k;
        logic [1:0] mode;
    } sweep_t;

    // mode 0: pass-through, 1: full sort, 2: invert, 3: sort all but lane 1
    localparam sweep_t TABLE [6] = '{
        '{k: 5'd5,  mode: 2'd0},
        '{k: 5'd4,  mode: 2'd1},
        '{k: 5'd6,  mode: 2'd2},
        '{k: 5'd3,  mode: 2'd3},
        '{k: 5'd1,  mode: 2'd0},
        '{k: 5'd16, mode: 2'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [4:0]  k_i = 5'd0;
    logic [15:0] test_vec_o;
    logic        pipe_flush_o;
    logic [15:0] pipe_res_i;
    logic [15:0] report_o;
    logic        done_o;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;
    int cur_k = 1;
    int cur_mode = 0;
    logic [15:0] prev_report = '0;

    always #4 clk = ~clk;

    zo_sweep_ctrl #(.LANES(16), .DEPTH(D)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .k_i          (k_i),
        .test_vec_o   (test_vec_o),
        .pipe_flush_o (pipe_flush_o),
        .pipe_res_i   (pipe_res_i),
        .report_o     (report_o),
        .done_o       (done_o)
    );

    function automatic int popc(int v, int k);
        int c = 0;
        for (int i = 0; i < k; i++) c += (v >> i) & 1;
        return c;
    endfunction

    function automatic int top_ones(int k, int ones);
        return ((1 << k) - 1) & ~((1 << (k - ones)) - 1);
    endfunction

    function automatic logic [15:0] model(logic [15:0] v, int k, int mode);
        int m = (1 << k) - 1;
        int x = int'(v) & m;
        int r;
        case (mode)
            1: r = top_ones(k, popc(x, k));
            2: r = ~x & m;
            3: r = (top_ones(k - 1, popc(x >> 1, k - 1)) << 1) | (x & 1);
            default: r = x;
        endcase
        return 16'(r);
    endfunction

    function automatic bit ordered(logic [15:0] w, int k);
        bit seen = 0;
        bit ok = 1;
        for (int i = 0; i < k; i++) begin
            if (w[i]) seen = 1;
            else if (seen) ok = 0;
        end
        return ok && seen;
    endfunction

    // External pipeline model: E register stages, cleared by the flush pulse.
    logic [15:0] pipe_q [E];
    always_ff @(posedge clk) begin
        if (pipe_flush_o) begin
            for (int i = 0; i < E; i++) pipe_q[i] <= '0;
        end else begin
            pipe_q[0] <= model(test_vec_o, cur_k, cur_mode);
            for (int i = 1; i < E; i++) pipe_q[i] <= pipe_q[i-1];
        end
    end
    assign pipe_res_i = pipe_q[E-1];

    task automatic chk(bit cond, string req, int act, int exp);
        n_run++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic sweep(int k, int mode);
        int c0 = (1 << k) - 2;
        int exp = 0;
        for (int v = 0; v <= c0; v++)
            if (ordered(model(16'(v), k, mode), k)) exp++;
        cur_k = k;
        cur_mode = mode;
        @(negedge clk);
        start_i = 1'b1;
        k_i = 5'(k);
        #1;
        chk(pipe_flush_o == 1'b1, "R1 flush", int'(pipe_flush_o), 1);
        @(negedge clk);
        start_i = 1'b0;
        chk(test_vec_o == 16'(c0), "R1 load", int'(test_vec_o), c0);
        chk(done_o == 1'b0, "R9 done cleared", int'(done_o), 0);
        chk(report_o == prev_report, "R9 report held", int'(report_o), int'(prev_report));
        for (int n = 1; n <= c0 + D; n++) begin
            @(negedge clk);
            if (n == 1 && c0 > 0)
                chk(test_vec_o == 16'(c0 - 1), "R2 step", int'(test_vec_o), c0 - 1);
            if (n == 2) begin
                start_i = 1'b1;
                k_i = 5'd3;
            end
            if (n == 3) start_i = 1'b0;
        end
        chk(done_o == 1'b0, "R6 done early", int'(done_o), 0);
        @(negedge clk);
        chk(done_o == 1'b1, "R6 done time", int'(done_o), 1);
        chk(report_o == 16'(exp), "R3 R4 R5 R7 report", int'(report_o), exp);
        chk(test_vec_o == '0, "R2 idle", int'(test_vec_o), 0);
        prev_report = report_o;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(done_o == 1'b0, "R8 done", int'(done_o), 0);
        chk(report_o == '0, "R8 report", int'(report_o), 0);
        chk(test_vec_o == '0, "R8 vec", int'(test_vec_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pipe_flush_o == 1'b0, "R8 flush", int'(pipe_flush_o), 0);
        foreach (TABLE[i]) sweep(int'(TABLE[i].k), int'(TABLE[i].mode));
        // Done held while idle with no start (R9)
        repeat (5) @(negedge clk);
        chk(done_o == 1'b1, "R9 hold", int'(done_o), 1);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule